// File: doc/BRIEF.md
# Protocol Discovery Enumerator

This block runs on the host side of a data-object mailbox. After the mailbox has been reset, a start pulse makes it walk the discovery protocol. It issues one single-dword request per step through a request/response task port to a mailbox engine. Each single-dword response is split into a vendor ID, a protocol type and the index of the next step. The (vendor ID, type) pair is stored in a small register table, and the walk follows the returned index until a response carries a next index of zero.

Two consumers read the table. A lookup port reports, in the same cycle, whether a given pair is supported. A task gate accepts or rejects an outgoing task. It rejects a task whose protocol is not supported, and it rejects a task whose request size in bytes is not a whole number of dwords. The discovery protocol itself counts as supported at all times, including before and during a walk.

Top module: `proto_catalog`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `req_valid` are 0, `err_cause` is 0 and `entry_count` is 0.
- R2: A start pulse while idle raises `req_valid` on the next cycle with `req_data` equal to 0, where the step index sits in bits 7:0 and all other bits are zero. `req_valid` and `req_data` hold steady until `req_ready` is seen.
- R3: Each accepted response stores vendor ID = bits 15:0 and type = bits 23:16. If bits 31:24 are nonzero, the next request carries that value in bits 7:0.
- R4: The walk ends after storing the entry whose next index is 0. At that point `done` is 1, `busy` is 0 and `entry_count` equals the number of entries stored. `done` and `error` are never both 1.
- R5: A response whose payload length `rsp_len` is not exactly 1 stops the walk. It sets `error` with `err_cause` = 1 (length) and stores nothing.
- R6: A valid response that arrives when `DEPTH` entries are already stored stops the walk. It sets `error` with `err_cause` = 2 (overflow), and `entry_count` stays at `DEPTH`.
- R7: A response flagged by the engine with `rsp_err` stops the walk. It sets `error` with `err_cause` = 3 (engine) and stores nothing.
- R8: A lookup of (`DISC_VID`, `DISC_TYPE`) returns `lk_hit` = 1 at all times, including right after reset and during a walk.
- R9: Any other lookup hits only if a stored entry matches both the vendor ID and the type. A pair that differs in either field misses.
- R10: When `tk_valid` is high, `tk_accept` is 1 only if the task's pair is supported and `tk_bytes` is a multiple of 4. Otherwise `tk_reject` is 1.
- R11: A start pulse during a walk is ignored, so the walk goes on from its current index. A start pulse after a walk has ended clears the table, so `entry_count` is 0 and the old pairs miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; ignored while busy |
| req_valid | output | 1 | Discovery request pending for the engine |
| req_ready | input | 1 | Engine takes the request |
| req_data | output | DW (32) | Request payload dword, index in bits 7:0 |
| rsp_valid | input | 1 | Response dword present for one cycle |
| rsp_data | input | DW (32) | Response dword: vendor 15:0, type 23:16, next 31:24 |
| rsp_len | input | LEN_W (11) | Response payload length in dwords |
| rsp_err | input | 1 | Engine reports a failed exchange |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last walk ended normally |
| error | output | 1 | Last walk stopped on an error |
| err_cause | output | 2 | 0 none, 1 length, 2 overflow, 3 engine |
| entry_count | output | CNT_W (3) | Entries stored in the table |
| lk_vid | input | VID_W (16) | Lookup vendor ID |
| lk_type | input | TYPE_W (8) | Lookup protocol type |
| lk_hit | output | 1 | Pair is supported |
| tk_valid | input | 1 | Task presented to the gate |
| tk_vid | input | VID_W (16) | Task vendor ID |
| tk_type | input | TYPE_W (8) | Task protocol type |
| tk_bytes | input | SZ_W (12) | Task request size in bytes |
| tk_accept | output | 1 | Task may proceed |
| tk_reject | output | 1 | Task refused |

## Verification
Some properties are checked by the assertions on every cycle. These are the request handshake hold and the zero first index after a start. They also cover the permanent hit for the discovery pair and the bound on the stored count, with overflow implying a full table. Misaligned tasks always being refused and `done`/`error` never both set are checked the same way. Field extraction, the order of indices along the chain, matching on both fields, and table clearing on restart all depend on stimulus sequences. Only the bench scenarios can show those, as can the three error causes and the fact that a start during a walk is ignored.

// File: rtl/proto_catalog_pkg.sv
package proto_catalog_pkg;

   typedef enum logic [1:0] {
      WALK_IDLE = 2'd0,
      WALK_SEND = 2'd1,
      WALK_WAIT = 2'd2
   } walk_state_e;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_LENGTH = 2'd1,
      CAUSE_OVERFL = 2'd2,
      CAUSE_ENGINE = 2'd3
   } fail_cause_e;

endpackage

// File: rtl/proto_catalog_walker.sv
module proto_catalog_walker
   import proto_catalog_pkg::*;
#(
   parameter int DW     = 32,
   parameter int VID_W  = 16,
   parameter int TYPE_W = 8,
   parameter int IDX_W  = 8,
   parameter int LEN_W  = 11,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [DW-1:0]     req_data,
   input  logic              rsp_valid,
   input  logic [DW-1:0]     rsp_data,
   input  logic [LEN_W-1:0]  rsp_len,
   input  logic              rsp_err,
   output logic              busy,
   output logic              done,
   output logic              error,
   output fail_cause_e       cause,
   output logic [CNT_W-1:0]  fill,
   output logic              wr_en,
   output logic [VID_W-1:0]  wr_vid,
   output logic [TYPE_W-1:0] wr_type
);

   localparam int TYPE_LSB = VID_W;
   localparam int NEXT_LSB = VID_W + TYPE_W;

   walk_state_e       state;
   logic [IDX_W-1:0]  step_idx;

   logic [IDX_W-1:0]  next_idx;
   logic              len_ok;
   logic              table_full;
   logic              take_rsp;

   assign next_idx   = rsp_data[NEXT_LSB +: IDX_W];
   assign wr_vid     = rsp_data[0 +: VID_W];
   assign wr_type    = rsp_data[TYPE_LSB +: TYPE_W];
   assign len_ok     = (rsp_len == LEN_W'(1));
   assign table_full = (fill == CNT_W'(DEPTH));
   assign take_rsp   = (state == WALK_WAIT) && rsp_valid;
   assign wr_en      = take_rsp && !rsp_err && len_ok && !table_full;

   assign busy      = (state != WALK_IDLE);
   assign req_valid = (state == WALK_SEND);
   assign req_data  = {{(DW-IDX_W){1'b0}}, step_idx};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= WALK_IDLE;
         step_idx <= '0;
         fill     <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
         cause    <= CAUSE_NONE;
      end else begin
         unique case (state)
            WALK_IDLE: begin
               if (start) begin
                  state    <= WALK_SEND;
                  step_idx <= '0;
                  fill     <= '0;
                  done     <= 1'b0;
                  error    <= 1'b0;
                  cause    <= CAUSE_NONE;
               end
            end
            WALK_SEND: begin
               if (req_ready) state <= WALK_WAIT;
            end
            WALK_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_err) begin
                     state <= WALK_IDLE;
                     error <= 1'b1;
                     cause <= CAUSE_ENGINE;
                  end else if (!len_ok) begin
                     state <= WALK_IDLE;
                     error <= 1'b1;
                     cause <= CAUSE_LENGTH;
                  end else if (table_full) begin
                     state <= WALK_IDLE;
                     error <= 1'b1;
                     cause <= CAUSE_OVERFL;
                  end else begin
                     fill <= fill + CNT_W'(1);
                     if (next_idx == '0) begin
                        state <= WALK_IDLE;
                        done  <= 1'b1;
                     end else begin
                        step_idx <= next_idx;
                        state    <= WALK_SEND;
                     end
                  end
               end
            end
            default: state <= WALK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/proto_catalog_table.sv
module proto_catalog_table #(
   parameter int              VID_W     = 16,
   parameter int              TYPE_W    = 8,
   parameter int              DEPTH     = 4,
   parameter int              CNT_W     = 3,
   parameter int              NPORT     = 2,
   parameter logic [15:0]     DISC_VID  = 16'h0001,
   parameter logic [7:0]      DISC_TYPE = 8'h00
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [CNT_W-1:0]              wr_ptr,
   input  logic [VID_W-1:0]              wr_vid,
   input  logic [TYPE_W-1:0]             wr_type,
   input  logic [CNT_W-1:0]              fill,
   input  logic [NPORT-1:0][VID_W-1:0]   q_vid,
   input  logic [NPORT-1:0][TYPE_W-1:0]  q_type,
   output logic [NPORT-1:0]              q_hit
);

   logic [VID_W-1:0]  ent_vid  [DEPTH];
   logic [TYPE_W-1:0] ent_type [DEPTH];
   logic [DEPTH-1:0]  ent_live;

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_vid[e]  <= '0;
            ent_type[e] <= '0;
         end else if (wr_en && (wr_ptr == CNT_W'(e))) begin
            ent_vid[e]  <= wr_vid;
            ent_type[e] <= wr_type;
         end
      end
      assign ent_live[e] = (fill > CNT_W'(e));
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [DEPTH-1:0] match;
      logic             is_disc;
      for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
         assign match[e] = ent_live[e] &&
                           (ent_vid[e] == q_vid[p]) &&
                           (ent_type[e] == q_type[p]);
      end
      assign is_disc  = (q_vid[p] == VID_W'(DISC_VID)) &&
                        (q_type[p] == TYPE_W'(DISC_TYPE));
      assign q_hit[p] = is_disc || (|match);
   end

endmodule

// File: rtl/proto_catalog_gate.sv
module proto_catalog_gate #(
   parameter int DW   = 32,
   parameter int SZ_W = 12
) (
   input  logic            tk_valid,
   input  logic [SZ_W-1:0] tk_bytes,
   input  logic            supported,
   output logic            tk_accept,
   output logic            tk_reject
);

   localparam int BPW  = DW / 8;
   localparam int AL_W = (BPW > 1) ? $clog2(BPW) : 1;

   logic aligned;

   if (BPW == 1) begin : g_byte_words
      assign aligned = 1'b1;
   end else if ((BPW & (BPW - 1)) == 0) begin : g_pow2
      assign aligned = (tk_bytes[AL_W-1:0] == '0);
   end else begin : g_modulo
      assign aligned = ((tk_bytes % SZ_W'(BPW)) == '0);
   end

   assign tk_accept = tk_valid && supported && aligned;
   assign tk_reject = tk_valid && !(supported && aligned);

endmodule

// File: rtl/proto_catalog.sv
module proto_catalog
   import proto_catalog_pkg::*;
#(
   parameter int          DW        = 32,
   parameter int          VID_W     = 16,
   parameter int          TYPE_W    = 8,
   parameter int          IDX_W     = 8,
   parameter int          LEN_W     = 11,
   parameter int          SZ_W      = 12,
   parameter int          DEPTH     = 4,
   parameter logic [15:0] DISC_VID  = 16'h0001,
   parameter logic [7:0]  DISC_TYPE = 8'h00,
   localparam int         CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [DW-1:0]     req_data,
   input  logic              rsp_valid,
   input  logic [DW-1:0]     rsp_data,
   input  logic [LEN_W-1:0]  rsp_len,
   input  logic              rsp_err,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [1:0]        err_cause,
   output logic [CNT_W-1:0]  entry_count,
   input  logic [VID_W-1:0]  lk_vid,
   input  logic [TYPE_W-1:0] lk_type,
   output logic              lk_hit,
   input  logic              tk_valid,
   input  logic [VID_W-1:0]  tk_vid,
   input  logic [TYPE_W-1:0] tk_type,
   input  logic [SZ_W-1:0]   tk_bytes,
   output logic              tk_accept,
   output logic              tk_reject
);

   localparam int NPORT = 2;

   if (DEPTH < 1) begin : g_bad_depth
      $error("proto_catalog: DEPTH must be at least 1");
   end
   if (VID_W + TYPE_W + IDX_W > DW) begin : g_bad_fields
      $error("proto_catalog: response fields exceed the dword");
   end
   if (IDX_W > DW || DW % 8 != 0) begin : g_bad_dw
      $error("proto_catalog: DW must be whole bytes and hold the index");
   end
   if (VID_W > 16 || TYPE_W > 8) begin : g_bad_ids
      $error("proto_catalog: identifier widths exceed the discovery constants");
   end

   fail_cause_e               cause;
   logic                      wr_en;
   logic [VID_W-1:0]          wr_vid;
   logic [TYPE_W-1:0]         wr_type;
   logic [NPORT-1:0][VID_W-1:0]  q_vid;
   logic [NPORT-1:0][TYPE_W-1:0] q_type;
   logic [NPORT-1:0]          q_hit;

   proto_catalog_walker #(
      .DW(DW), .VID_W(VID_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W),
      .LEN_W(LEN_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
   ) u_walker (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_len(rsp_len),
      .rsp_err(rsp_err),
      .busy(busy), .done(done), .error(error), .cause(cause),
      .fill(entry_count),
      .wr_en(wr_en), .wr_vid(wr_vid), .wr_type(wr_type)
   );

   assign q_vid[0]  = lk_vid;
   assign q_type[0] = lk_type;
   assign q_vid[1]  = tk_vid;
   assign q_type[1] = tk_type;

   proto_catalog_table #(
      .VID_W(VID_W), .TYPE_W(TYPE_W), .DEPTH(DEPTH), .CNT_W(CNT_W),
      .NPORT(NPORT), .DISC_VID(DISC_VID), .DISC_TYPE(DISC_TYPE)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_ptr(entry_count), .wr_vid(wr_vid), .wr_type(wr_type),
      .fill(entry_count),
      .q_vid(q_vid), .q_type(q_type), .q_hit(q_hit)
   );

   assign lk_hit    = q_hit[0];
   assign err_cause = cause;

   proto_catalog_gate #(
      .DW(DW), .SZ_W(SZ_W)
   ) u_gate (
      .tk_valid(tk_valid), .tk_bytes(tk_bytes), .supported(q_hit[1]),
      .tk_accept(tk_accept), .tk_reject(tk_reject)
   );

endmodule

// File: rtl/proto_catalog_checker.sv
module proto_catalog_checker #(
   parameter int          DW        = 32,
   parameter int          VID_W     = 16,
   parameter int          TYPE_W    = 8,
   parameter int          SZ_W      = 12,
   parameter int          DEPTH     = 4,
   parameter int          CNT_W     = 3,
   parameter logic [15:0] DISC_VID  = 16'h0001,
   parameter logic [7:0]  DISC_TYPE = 8'h00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              req_valid,
   input logic              req_ready,
   input logic [DW-1:0]     req_data,
   input logic              busy,
   input logic              done,
   input logic              error,
   input logic [1:0]        err_cause,
   input logic [CNT_W-1:0]  entry_count,
   input logic [VID_W-1:0]  lk_vid,
   input logic [TYPE_W-1:0] lk_type,
   input logic              lk_hit,
   input logic              tk_valid,
   input logic [SZ_W-1:0]   tk_bytes,
   input logic              tk_accept,
   input logic              tk_reject
);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid)
      else $error("idle block presents a request");

   p_first_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (req_valid && req_data == '0))
      else $error("walk did not open with index zero");

   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_data)))
      else $error("request dropped or changed before acceptance");

   p_end_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error))
      else $error("done and error both set");

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      entry_count <= CNT_W'(DEPTH))
      else $error("stored count exceeds depth");

   p_overflow_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (error && err_cause == 2'd2) |-> (entry_count == CNT_W'(DEPTH)))
      else $error("overflow reported with room left");

   p_disc_always_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_vid == VID_W'(DISC_VID) && lk_type == TYPE_W'(DISC_TYPE)) |-> lk_hit)
      else $error("discovery pair reported unsupported");

   p_misaligned_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tk_valid && tk_bytes[1:0] != 2'b00) |-> (!tk_accept && tk_reject))
      else $error("misaligned task accepted");

endmodule

bind proto_catalog proto_catalog_checker #(
   .DW(DW), .VID_W(VID_W), .TYPE_W(TYPE_W), .SZ_W(SZ_W), .DEPTH(DEPTH),
   .CNT_W(CNT_W), .DISC_VID(DISC_VID), .DISC_TYPE(DISC_TYPE)
) u_checker (
   .clk(clk), .rst_n(rst_n), .start(start),
   .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
   .busy(busy), .done(done), .error(error), .err_cause(err_cause),
   .entry_count(entry_count),
   .lk_vid(lk_vid), .lk_type(lk_type), .lk_hit(lk_hit),
   .tk_valid(tk_valid), .tk_bytes(tk_bytes),
   .tk_accept(tk_accept), .tk_reject(tk_reject)
);

// File: tb/proto_catalog_bench.sv
module proto_catalog_bench;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [31:0] req_data;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_data = '0;
   logic [10:0] rsp_len = '0;
   logic        rsp_err = 1'b0;
   logic        busy, done, error;
   logic [1:0]  err_cause;
   logic [2:0]  entry_count;
   logic [15:0] lk_vid = '0;
   logic [7:0]  lk_type = '0;
   logic        lk_hit;
   logic        tk_valid = 1'b0;
   logic [15:0] tk_vid = '0;
   logic [7:0]  tk_type = '0;
   logic [11:0] tk_bytes = '0;
   logic        tk_accept, tk_reject;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   proto_catalog #(.DEPTH(DEPTH)) u_proto_catalog (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_len(rsp_len),
      .rsp_err(rsp_err),
      .busy(busy), .done(done), .error(error), .err_cause(err_cause),
      .entry_count(entry_count),
      .lk_vid(lk_vid), .lk_type(lk_type), .lk_hit(lk_hit),
      .tk_valid(tk_valid), .tk_vid(tk_vid), .tk_type(tk_type),
      .tk_bytes(tk_bytes), .tk_accept(tk_accept), .tk_reject(tk_reject)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input logic [15:0] v,
                                        input logic [7:0] t,
                                        input logic [7:0] nxt);
      return {nxt, t, v};
   endfunction

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Waits for a request, optionally stalls, accepts it, then returns one response.
   task automatic serve(input logic [31:0] rsp, input int len, input logic eerr,
                        input int stall, output logic [31:0] seen);
      int guard = 0;
      while (!req_valid && guard < 50) begin
         @(negedge clk);
         guard++;
      end
      seen = req_data;
      for (int s = 0; s < stall; s++) begin
         @(negedge clk);
         chk("R2", "request held during stall", {31'b0, req_valid}, 32'd1);
         chk("R2", "request data stable", req_data, seen);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      rsp_valid = 1'b1;
      rsp_data  = rsp;
      rsp_len   = 11'(len);
      rsp_err   = eerr;
      @(negedge clk);
      rsp_valid = 1'b0;
      rsp_err   = 1'b0;
   endtask

   task automatic lookup(input string req, input logic [15:0] v,
                         input logic [7:0] t, input logic exp);
      lk_vid  = v;
      lk_type = t;
      #1;
      chk(req, $sformatf("lookup %h/%h", v, t), {31'b0, lk_hit}, {31'b0, exp});
   endtask

   task automatic gate(input logic [15:0] v, input logic [7:0] t,
                       input logic [11:0] bytes, input logic exp_acc);
      tk_valid = 1'b1;
      tk_vid   = v;
      tk_type  = t;
      tk_bytes = bytes;
      #1;
      chk("R10", $sformatf("accept %h/%h %0d bytes", v, t, bytes),
          {31'b0, tk_accept}, {31'b0, exp_acc});
      chk("R10", "reject is complement", {31'b0, tk_reject}, {31'b0, !exp_acc});
      tk_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "busy", {31'b0, busy}, 0);
      chk("R1", "done", {31'b0, done}, 0);
      chk("R1", "error", {31'b0, error}, 0);
      chk("R1", "req_valid", {31'b0, req_valid}, 0);
      chk("R1", "err_cause", {30'b0, err_cause}, 0);
      chk("R1", "entry_count", {29'b0, entry_count}, 0);
      lookup("R8", 16'h0001, 8'h00, 1'b1);
      lookup("R9", 16'h1E98, 8'h02, 1'b0);
   endtask

   task automatic t_chain();
      logic [31:0] seen;
      pulse_start();
      chk("R2", "first request valid", {31'b0, req_valid}, 1);
      lookup("R8", 16'h0001, 8'h00, 1'b1);
      serve(word(16'h0001, 8'h00, 8'h01), 1, 1'b0, 2, seen);
      chk("R2", "first index", seen, 32'h0);
      serve(word(16'h1E98, 8'h02, 8'h07), 1, 1'b0, 0, seen);
      chk("R3", "second index", seen, 32'h1);
      serve(word(16'h1E98, 8'h05, 8'h00), 1, 1'b0, 0, seen);
      chk("R3", "third index from bits 31:24", seen, 32'h7);
      chk("R4", "done", {31'b0, done}, 1);
      chk("R4", "busy", {31'b0, busy}, 0);
      chk("R4", "error", {31'b0, error}, 0);
      chk("R4", "entry_count", {29'b0, entry_count}, 3);
      lookup("R3", 16'h1E98, 8'h02, 1'b1);
      lookup("R3", 16'h1E98, 8'h05, 1'b1);
      lookup("R9", 16'h1E98, 8'h03, 1'b0);
      lookup("R9", 16'h1E99, 8'h02, 1'b0);
      lookup("R9", 16'h0502, 8'h98, 1'b0);
      gate(16'h1E98, 8'h02, 12'd8, 1'b1);
      gate(16'h1E98, 8'h02, 12'd6, 1'b0);
      gate(16'h1234, 8'h01, 12'd4, 1'b0);
      gate(16'h0001, 8'h00, 12'd4, 1'b1);
      gate(16'h0001, 8'h00, 12'd3, 1'b0);
   endtask

   task automatic t_length(input int len);
      logic [31:0] seen;
      pulse_start();
      serve(word(16'h0001, 8'h00, 8'h02), len, 1'b0, 0, seen);
      chk("R5", "error", {31'b0, error}, 1);
      chk("R5", "cause length", {30'b0, err_cause}, 1);
      chk("R5", "nothing stored", {29'b0, entry_count}, 0);
      chk("R5", "walk stopped", {31'b0, busy}, 0);
      chk("R4", "done low on error", {31'b0, done}, 0);
   endtask

   task automatic t_engine();
      logic [31:0] seen;
      pulse_start();
      serve(word(16'h0001, 8'h00, 8'h00), 1, 1'b1, 0, seen);
      chk("R7", "error", {31'b0, error}, 1);
      chk("R7", "cause engine", {30'b0, err_cause}, 3);
      chk("R7", "nothing stored", {29'b0, entry_count}, 0);
   endtask

   task automatic t_overflow();
      logic [31:0] seen;
      pulse_start();
      for (int k = 0; k < DEPTH + 1; k++) begin
         serve(word(16'h2000 + 16'(k), 8'(k), 8'(k + 1)), 1, 1'b0, 0, seen);
         if (k < DEPTH) chk("R3", "chained index", seen, 32'(k));
      end
      chk("R6", "error", {31'b0, error}, 1);
      chk("R6", "cause overflow", {30'b0, err_cause}, 2);
      chk("R6", "count at depth", {29'b0, entry_count}, DEPTH);
      chk("R6", "walk stopped", {31'b0, req_valid}, 0);
      lookup("R6", 16'h2003, 8'h03, 1'b1);
      lookup("R6", 16'h2004, 8'h04, 1'b0);
   endtask

   task automatic t_restart();
      logic [31:0] seen;
      pulse_start();
      serve(word(16'h0001, 8'h00, 8'h03), 1, 1'b0, 0, seen);
      pulse_start();
      chk("R11", "still busy", {31'b0, busy}, 1);
      serve(word(16'h4455, 8'h09, 8'h00), 1, 1'b0, 0, seen);
      chk("R11", "start during walk ignored", seen, 32'h3);
      chk("R11", "count after walk", {29'b0, entry_count}, 2);
      lookup("R11", 16'h4455, 8'h09, 1'b1);
      pulse_start();
      chk("R11", "table cleared", {29'b0, entry_count}, 0);
      lookup("R11", 16'h4455, 8'h09, 1'b0);
      lookup("R8", 16'h0001, 8'h00, 1'b1);
      serve(word(16'h0001, 8'h00, 8'h00), 1, 1'b0, 0, seen);
      chk("R4", "single-entry walk", {29'b0, entry_count}, 1);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_chain();
      t_length(2);
      t_length(0);
      t_engine();
      t_overflow();
      t_restart();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

endmodule